// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block collects up to 64 level-sensitive interrupt requests and presents one of them to a CPU. Each source has an enable bit and a 4-bit priority. Software reaches these through a small 32-bit register bus made of an address, write data, a write strobe and combinational read data. Each cycle the controller finds the highest-priority request that is pending, enabled and mapped. It registers that result and drives it out as a valid flag, a 4-bit level and a 12-bit event code.

Enable bits are never written directly. One set of addresses turns enables on for every 1 bit in the written word, and a second set turns them off. A zero bit leaves its enable as it was. Priorities are packed eight to a 32-bit word. The event code for a source is a fixed vector number times 0x20, and sources with no vector can never be reported. A mode bit decides whether the four external request lines, sources 0 to 3, take part in arbitration.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_valid is 0, the mode bit reads 0, every enable reads 0 and every priority word reads 0.
- R2: A write to 0x70 sets the enable of source n for each set bit n. A write to 0x78 does the same for source 32+n. Zero bits leave enables unchanged. 0x70 and 0x78 read back the current enables.
- R3: A write to 0x80 clears the enable of source n for each set bit n. A write to 0x88 does the same for source 32+n. Zero bits leave enables unchanged.
- R4: Priority word k sits at 0x10+8k, for k from 0 to 7. Source i uses word i/8, bits (i mod 8)*4 upward, and the word reads back as written.
- R5: A write with bit 0 set to 0x00 sets the mode bit. A write with bit 0 set to 0x08 clears it. Reading 0x00 returns the mode bit in bit 0.
- R6: With the mode bit at 0, sources 0 to 3 never win arbitration. With the mode bit at 1, they arbitrate like any other source.
- R7: The reported level is the highest priority among eligible sources. When two sources tie, the lower source number wins.
- R8: irq_code is the source's vector times 0x20. The vectors are: 0x12, 0x15, 0x18, 0x1B for sources 0 to 3; 0x40 to 0x43 for sources 4 to 7; 0x50 to 0x55 for sources 12 to 17; 0x32 to 0x36 for sources 18 to 22; 0x20 to 0x26 for sources 32 to 38; 0x38 to 0x3B for sources 39 to 42; and 0x2B for source 63. Every other source is never reported.
- R9: A source with priority 0 never wins, even when it is enabled and requesting.
- R10: 0x60 and 0x68 read the raw requests of sources 0 to 31 and 32 to 63. 0x50 and 0x58 read the same requests ANDed with the enables.
- R11: The irq outputs are registered. They reflect the requests and registers as they stood at the previous rising edge.
- R12: Reads of unmapped offsets (including 0x08, 0x80 and 0x88) return 0. Writes to the status offsets 0x50 to 0x68 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| src_req | input | 64 | Level-sensitive source requests |
| irq_valid | output | 1 | A request is being presented |
| irq_level | output | 4 | Priority of the presented request |
| irq_code | output | 12 | Event code of the presented request |

## Verification
The bench aims at the set and clear enable paths with partial masks. A design that treats a zero bit as a write would wipe enables that other sources depend on, and the read-back exposes this. It also tests a tie at equal priority, a source with priority 0, an enabled and prioritised source that has no vector, and the external lines under both mode settings. A design that picked the higher source number, let a priority of 0 through, or reported an unmapped source would show a wrong level or code, or a valid flag that should be low. Status reads after writes to read-only offsets catch a design that lets those writes through, and a check taken before the next edge catches outputs that are not registered.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic [63:0]       src_req,
  output logic              irq_valid,
  output logic [3:0]        irq_level,
  output logic [11:0]       irq_code
);
  localparam int NSRC = 64;
  localparam int NPW  = 8;
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_PRI   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_PEND0 = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] A_PEND1 = ADDR_W'('h58);
  localparam logic [ADDR_W-1:0] A_RAW0  = ADDR_W'('h60);
  localparam logic [ADDR_W-1:0] A_RAW1  = ADDR_W'('h68);
  localparam logic [ADDR_W-1:0] A_ON0   = ADDR_W'('h70);
  localparam logic [ADDR_W-1:0] A_ON1   = ADDR_W'('h78);
  localparam logic [ADDR_W-1:0] A_OFF0  = ADDR_W'('h80);
  localparam logic [ADDR_W-1:0] A_OFF1  = ADDR_W'('h88);

  function automatic logic [6:0] vec_of(input int s);
    if (s == 0)                 return 7'h12;
    else if (s == 1)            return 7'h15;
    else if (s == 2)            return 7'h18;
    else if (s == 3)            return 7'h1B;
    else if (s >= 4 && s <= 7)   return 7'(7'h40 + s - 4);
    else if (s >= 12 && s <= 17) return 7'(7'h50 + s - 12);
    else if (s >= 18 && s <= 22) return 7'(7'h32 + s - 18);
    else if (s >= 32 && s <= 38) return 7'(7'h20 + s - 32);
    else if (s >= 39 && s <= 42) return 7'(7'h38 + s - 39);
    else if (s == 63)           return 7'h2B;
    else                        return 7'h00;
  endfunction

  logic [63:0] en_q;
  logic        mode_q;
  logic [31:0] pri_q [NPW];
  logic [63:0] mapped;
  logic [63:0] cand;

  for (genvar g = 0; g < NSRC; g++) begin : g_map
    assign mapped[g] = (vec_of(g) != 7'h00);
  end

  assign cand = src_req & en_q & mapped & {{(NSRC-4){1'b1}}, {4{mode_q}}};

  logic [ADDR_W-1:0] pofs;
  logic              pri_hit;
  assign pofs    = bus_addr - A_PRI;
  assign pri_hit = (bus_addr >= A_PRI) && (bus_addr < A_PEND0) && (bus_addr[2:0] == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= 1'b0;
      for (int k = 0; k < NPW; k++) pri_q[k] <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_MSET && bus_wdata[0]) mode_q <= 1'b1;
      if (bus_addr == A_MCLR && bus_wdata[0]) mode_q <= 1'b0;
      if (bus_addr == A_ON0)  en_q[31:0]  <= en_q[31:0]  | bus_wdata;
      if (bus_addr == A_ON1)  en_q[63:32] <= en_q[63:32] | bus_wdata;
      if (bus_addr == A_OFF0) en_q[31:0]  <= en_q[31:0]  & ~bus_wdata;
      if (bus_addr == A_OFF1) en_q[63:32] <= en_q[63:32] & ~bus_wdata;
      if (pri_hit) pri_q[pofs[5:3]] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (pri_hit) bus_rdata = pri_q[pofs[5:3]];
    else begin
      case (bus_addr)
        A_MSET:  bus_rdata = {31'd0, mode_q};
        A_PEND0: bus_rdata = src_req[31:0]  & en_q[31:0];
        A_PEND1: bus_rdata = src_req[63:32] & en_q[63:32];
        A_RAW0:  bus_rdata = src_req[31:0];
        A_RAW1:  bus_rdata = src_req[63:32];
        A_ON0:   bus_rdata = en_q[31:0];
        A_ON1:   bus_rdata = en_q[63:32];
        default: bus_rdata = '0;
      endcase
    end
  end

  logic [3:0]  best_lvl;
  logic [11:0] best_code;
  always_comb begin
    best_lvl  = '0;
    best_code = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && pri_q[i/NPW][(i%NPW)*4 +: 4] > best_lvl) begin
        best_lvl  = pri_q[i/NPW][(i%NPW)*4 +: 4];
        best_code = {vec_of(i), 5'd0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_level <= '0;
      irq_code  <= '0;
    end else begin
      irq_valid <= (best_lvl != 4'd0);
      irq_level <= best_lvl;
      irq_code  <= best_code;
    end
  end
endmodule

// File: rtl/prio_intc_checks.sv
module prio_intc_checks #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic [63:0]       src_req,
  input logic [63:0]       en_q,
  input logic              mode_q,
  input logic              irq_valid,
  input logic [3:0]        irq_level,
  input logic [11:0]       irq_code
);
  // R7
  valid_has_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level != 4'd0);
  // R8
  valid_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_code != 12'd0);
  // R11
  quiet_follows_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req == 64'd0) |=> !irq_valid);
  // R2
  enable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h70)) |=> ((en_q[31:0] & $past(bus_wdata)) == $past(bus_wdata)));
  // R3
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h88)) |=> ((en_q[63:32] & $past(bus_wdata)) == 32'd0));
  // R5
  mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h00) && bus_wdata[0]) |=> mode_q);
  // R12
  status_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr >= ADDR_W'('h50) && bus_addr <= ADDR_W'('h68)) |=> ($stable(en_q) && $stable(mode_q)));
endmodule

bind prio_intc prio_intc_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .src_req(src_req), .en_q(en_q), .mode_q(mode_q),
  .irq_valid(irq_valid), .irq_level(irq_level), .irq_code(irq_code)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [63:0] src_req = '0;
  logic        irq_valid;
  logic [3:0]  irq_level;
  logic [11:0] irq_code;
  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .src_req(src_req),
    .irq_valid(irq_valid), .irq_level(irq_level), .irq_code(irq_code)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; #1;
    nchk++;
    if (bus_rdata !== exp) begin
      nfail++;
      $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic irq(input logic v, input logic [3:0] l, input logic [11:0] c, input string req);
    nchk++;
    if (irq_valid !== v || irq_level !== l || irq_code !== c) begin
      nfail++;
      $display("FAIL %s: irq got v=%0b l=%0h c=%03h expected v=%0b l=%0h c=%03h",
               req, irq_valid, irq_level, irq_code, v, l, c);
    end
  endtask

  task automatic t_reset();
    irq(1'b0, 4'h0, 12'h000, "R1 outputs");
    rd(8'h00, 32'h0, "R1 mode");
    rd(8'h70, 32'h0, "R1 enable lo");
    rd(8'h78, 32'h0, "R1 enable hi");
    rd(8'h10, 32'h0, "R1 prio0");
    rd(8'h48, 32'h0, "R1 prio7");
  endtask

  task automatic t_enables();
    wr(8'h70, 32'h0000_00F0);
    wr(8'h70, 32'h0000_1000);
    rd(8'h70, 32'h0000_10F0, "R2 set keeps other bits");
    wr(8'h78, 32'h8000_0000);
    rd(8'h78, 32'h8000_0000, "R2 upper bank");
    wr(8'h80, 32'h0000_0030);
    rd(8'h70, 32'h0000_10C0, "R3 clear lo");
    wr(8'h88, 32'h0000_0000);
    rd(8'h78, 32'h8000_0000, "R3 zero mask no effect");
  endtask

  task automatic t_prio();
    wr(8'h10, 32'h7654_3210);
    rd(8'h10, 32'h7654_3210, "R4 word0");
    wr(8'h48, 32'h9000_0000);
    rd(8'h48, 32'h9000_0000, "R4 word7");
  endtask

  task automatic t_arb();
    src_req = 64'h0000_0000_0000_00C0;
    irq(1'b0, 4'h0, 12'h000, "R11 not yet visible");
    step();
    irq(1'b1, 4'h7, 12'h860, "R7 highest of 6,7");
    src_req[63] = 1'b1;
    step();
    irq(1'b1, 4'h9, 12'h560, "R8 source 63 code");
    wr(8'h18, 32'h0009_0000);
    src_req = 64'h8000_0000_0000_1000;
    step();
    irq(1'b1, 4'h9, 12'hA00, "R7 tie lowest index");
  endtask

  task automatic t_zero_and_unmapped();
    wr(8'h70, 32'h0000_0010);
    wr(8'h10, 32'h7650_3210);
    src_req = 64'h0000_0000_0000_0010;
    step();
    irq(1'b0, 4'h0, 12'h000, "R9 priority zero");
    wr(8'h70, 32'h0000_0100);
    wr(8'h18, 32'h0009_000F);
    src_req = 64'h0000_0000_0000_0100;
    step();
    irq(1'b0, 4'h0, 12'h000, "R8 unmapped source");
  endtask

  task automatic t_mode();
    wr(8'h70, 32'h0000_0001);
    wr(8'h10, 32'h7650_3215);
    src_req = 64'h0000_0000_0000_0001;
    step();
    irq(1'b0, 4'h0, 12'h000, "R6 mode 0 excludes line");
    wr(8'h00, 32'h0000_0001);
    rd(8'h00, 32'h1, "R5 mode set");
    step();
    irq(1'b1, 4'h5, 12'h240, "R6 mode 1 includes line");
    wr(8'h08, 32'h0000_0001);
    rd(8'h00, 32'h0, "R5 mode clear");
    step();
    irq(1'b0, 4'h0, 12'h000, "R6 mode cleared again");
  endtask

  task automatic t_status();
    src_req = 64'h8000_0000_0000_2101;
    rd(8'h60, 32'h0000_2101, "R10 raw lo");
    rd(8'h68, 32'h8000_0000, "R10 raw hi");
    rd(8'h50, 32'h0000_0101, "R10 pending lo");
    rd(8'h58, 32'h8000_0000, "R10 pending hi");
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h68, 32'h0000_0001);
    rd(8'h70, 32'h0000_11D1, "R12 enables untouched");
    rd(8'h50, 32'h0000_0101, "R12 status untouched");
    rd(8'h00, 32'h0, "R12 mode untouched");
    rd(8'h08, 32'h0, "R12 unmapped 0x08");
    rd(8'h80, 32'h0, "R12 unmapped 0x80");
    rd(8'h0C, 32'h0, "R12 unmapped 0x0C");
    rd(8'h98, 32'h0, "R12 unmapped 0x98");
  endtask

  initial begin
    #(8 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_enables();
    t_prio();
    t_arb();
    t_zero_and_unmapped();
    t_mode();
    t_status();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule